// File: doc/BRIEF.md
# Dual-Selector Ripple Arithmetic Unit

This block is a purely combinational integer arithmetic unit of parameterized width. Each of its two operand words first passes through its own three-way conditioner, which can replace the word with zero, invert every bit, or leave it untouched. The two conditioned words and a single carry-in bit then enter a chain of full-adder bit slices. The low slice takes the carry-in, and the top slice produces the unit's carry output.

A 3-bit operation code chooses the two conditioner settings and the carry-in through a small decoder. Because both operands can be conditioned, one adder chain covers addition, addition plus one, subtraction in both directions, increment, transfer and negation of either operand. There is no clock, no storage and no handshake. The outputs follow the inputs after the combinational settling delay. The only data interface is a set of plain operand pins, so there is no valid/ready back-pressure to honour.

Top module: `arith_dual_sel_unit`

## Requirements
- R1: The width parameter WIDTH defaults to 4. The result is the WIDTH-bit sum of the two conditioned words plus the carry-in, taken modulo 2^WIDTH, and carry_out is bit WIDTH of that sum.
- R2: Each operand conditioner uses a 2-bit setting: 00 gives an all-zero word, 01 gives the bitwise inverse, and both 10 and 11 give the operand unchanged.
- R3: Code 000 gives A+B, with carry_out set when the true sum reaches 2^WIDTH.
- R4: Code 001 gives A+B+1.
- R5: Code 010 gives A-B, computed as A + ~B + 1, with carry_out equal to 1 exactly when A >= B.
- R6: Code 011 gives B-A, computed as ~A + B + 1, with carry_out equal to 1 exactly when B >= A.
- R7: Code 100 gives A+1, with carry_out set only when A is all ones.
- R8: Code 101 passes A through unchanged, with carry_out 0.
- R9: Code 110 gives -A, computed as ~A + 1, with carry_out set only when A is zero.
- R10: Code 111 gives -B, computed as ~B + 1, with carry_out set only when B is zero.
- R11: The outputs depend only on the present inputs. A new operand or code value appears at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand word |
| opnd_b | input | WIDTH | Second operand word |
| op_code | input | 3 | Operation select code |
| result | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry from the most significant slice |

## Verification
The assertions are evaluated whenever an input changes. They check, for every applied combination, the plain-sum value, the subtraction carry as an ordering of A against B, the transfer and negation results, and the increment carry. The bench's scenarios are the only place where every operation code is swept against every operand pair. They also cover the boundary values (zero, all ones, equal operands) and show that the outputs track input changes with no clock edge in between.

// File: rtl/arith_dsu_pkg.sv
package arith_dsu_pkg;

  localparam int OP_BITS  = 3;
  localparam int SEL_BITS = 2;

  typedef enum logic [SEL_BITS-1:0] {
    SEL_ZERO     = 2'b00,
    SEL_INV      = 2'b01,
    SEL_PASS     = 2'b10,
    SEL_PASS_ALT = 2'b11
  } opnd_sel_e;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD     = 3'b000,
    OP_ADD_INC = 3'b001,
    OP_SUB_AB  = 3'b010,
    OP_SUB_BA  = 3'b011,
    OP_INC_A   = 3'b100,
    OP_MOV_A   = 3'b101,
    OP_NEG_A   = 3'b110,
    OP_NEG_B   = 3'b111
  } op_code_e;

  typedef struct packed {
    opnd_sel_e sel_a;
    opnd_sel_e sel_b;
    logic      carry_in;
  } ctl_word_t;

endpackage

// File: rtl/arith_op_decode.sv
module arith_op_decode
  import arith_dsu_pkg::*;
(
  input  logic [OP_BITS-1:0] op_code,
  output ctl_word_t          ctl
);

  always_comb begin
    ctl = '{sel_a: SEL_PASS, sel_b: SEL_PASS, carry_in: 1'b0};
    case (op_code_e'(op_code))
      OP_ADD:     ctl = '{sel_a: SEL_PASS, sel_b: SEL_PASS, carry_in: 1'b0};
      OP_ADD_INC: ctl = '{sel_a: SEL_PASS, sel_b: SEL_PASS, carry_in: 1'b1};
      OP_SUB_AB:  ctl = '{sel_a: SEL_PASS, sel_b: SEL_INV,  carry_in: 1'b1};
      OP_SUB_BA:  ctl = '{sel_a: SEL_INV,  sel_b: SEL_PASS, carry_in: 1'b1};
      OP_INC_A:   ctl = '{sel_a: SEL_PASS, sel_b: SEL_ZERO, carry_in: 1'b1};
      OP_MOV_A:   ctl = '{sel_a: SEL_PASS, sel_b: SEL_ZERO, carry_in: 1'b0};
      OP_NEG_A:   ctl = '{sel_a: SEL_INV,  sel_b: SEL_ZERO, carry_in: 1'b1};
      OP_NEG_B:   ctl = '{sel_a: SEL_ZERO, sel_b: SEL_INV,  carry_in: 1'b1};
      default:    ctl = '{sel_a: SEL_PASS, sel_b: SEL_PASS, carry_in: 1'b0};
    endcase
  end

endmodule

// File: rtl/arith_opnd_sel.sv
module arith_opnd_sel
  import arith_dsu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  opnd_sel_e        sel,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out
);

  always_comb begin
    case (sel)
      SEL_ZERO:     word_out = '0;
      SEL_INV:      word_out = ~word_in;
      SEL_PASS:     word_out = word_in;
      SEL_PASS_ALT: word_out = word_in;
      default:      word_out = word_in;
    endcase
  end

endmodule

// File: rtl/arith_bit_slice.sv
module arith_bit_slice (
  input  logic bit_x,
  input  logic bit_y,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);

  logic half_sum;

  always_comb begin
    half_sum = bit_x ^ bit_y;
    s_out    = half_sum ^ c_in;
    c_out    = (bit_x & bit_y) | (half_sum & c_in);
  end

endmodule

// File: rtl/arith_ripple_chain.sv
module arith_ripple_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] word_x,
  input  logic [WIDTH-1:0] word_y,
  input  logic             c_first,
  output logic [WIDTH-1:0] sum,
  output logic             c_last
);

  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry_vec;

  assign carry_vec[0] = c_first;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    arith_bit_slice u_slice (
      .bit_x (word_x[i]),
      .bit_y (word_y[i]),
      .c_in  (carry_vec[i]),
      .s_out (sum[i]),
      .c_out (carry_vec[i+1])
    );
  end

  assign c_last = carry_vec[NCARRY-1];

endmodule

// File: rtl/arith_dual_sel_unit.sv
module arith_dual_sel_unit
  import arith_dsu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  input  logic [OP_BITS-1:0] op_code,
  output logic [WIDTH-1:0]   result,
  output logic               carry_out
);

  ctl_word_t        ctl;
  logic [WIDTH-1:0] cond_a;
  logic [WIDTH-1:0] cond_b;

  arith_op_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  arith_opnd_sel #(.WIDTH(WIDTH)) u_sel_a (
    .sel      (ctl.sel_a),
    .word_in  (opnd_a),
    .word_out (cond_a)
  );

  arith_opnd_sel #(.WIDTH(WIDTH)) u_sel_b (
    .sel      (ctl.sel_b),
    .word_in  (opnd_b),
    .word_out (cond_b)
  );

  arith_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .word_x  (cond_a),
    .word_y  (cond_b),
    .c_first (ctl.carry_in),
    .sum     (result),
    .c_last  (carry_out)
  );

endmodule

// File: rtl/arith_dual_sel_chk.sv
module arith_dual_sel_chk
  import arith_dsu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]   opnd_a,
  input logic [WIDTH-1:0]   opnd_b,
  input logic [OP_BITS-1:0] op_code,
  input logic [WIDTH-1:0]   result,
  input logic               carry_out
);

  logic [WIDTH:0] wide_a;
  logic [WIDTH:0] wide_b;
  logic [WIDTH:0] wide_got;
  logic           known;

  always_comb begin
    wide_a   = {1'b0, opnd_a};
    wide_b   = {1'b0, opnd_b};
    wide_got = {carry_out, result};
    known    = !$isunknown({opnd_a, opnd_b, op_code, result, carry_out});
    if (known) begin
      if (op_code == OP_ADD)
        AST_ADD_SUM: assert (wide_got == wide_a + wide_b); // R3
      if (op_code == OP_SUB_AB)
        AST_SUB_CARRY: assert (carry_out == (opnd_a >= opnd_b)); // R5
      if (op_code == OP_SUB_BA)
        AST_RSUB_CARRY: assert (carry_out == (opnd_b >= opnd_a)); // R6
      if (op_code == OP_INC_A)
        AST_INC_CARRY: assert (carry_out == (&opnd_a)); // R7
      if (op_code == OP_MOV_A)
        AST_MOV_PASS: assert (result == opnd_a && !carry_out); // R8
      if (op_code == OP_NEG_A)
        AST_NEG_A_VAL: assert (result == WIDTH'(-opnd_a) && carry_out == (opnd_a == '0)); // R9
      if (op_code == OP_NEG_B)
        AST_NEG_B_VAL: assert (result == WIDTH'(-opnd_b) && carry_out == (opnd_b == '0)); // R10
    end
  end

endmodule

bind arith_dual_sel_unit arith_dual_sel_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_code   (op_code),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/tb_arith_dual_sel_unit.sv
`timescale 1ns/1ps
module tb_arith_dual_sel_unit;

  localparam int W   = 4;
  localparam int MOD = 1 << W;
  localparam int MAXV = MOD - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [2:0]   op_code = '0;
  logic [W-1:0] result;
  logic         carry_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  arith_dual_sel_unit #(.WIDTH(W)) dut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .result    (result),
    .carry_out (carry_out)
  );

  // reference value (W+1 bits) derived from the operation table
  function automatic int ref_val(int op, int a, int b);
    case (op)
      0: return a + b;
      1: return a + b + 1;
      2: return a - b + MOD;
      3: return b - a + MOD;
      4: return a + 1;
      5: return a;
      6: return MOD - a;
      default: return MOD - b;
    endcase
  endfunction

  task automatic check(string req, int exp);
    int got;
    got = int'({carry_out, result});
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d got carry=%0d res=%0d expected carry=%0d res=%0d",
               req, op_code, opnd_a, opnd_b, got >> W, got % MOD, exp >> W, exp % MOD);
    end
  endtask

  task automatic apply(int op, int a, int b);
    @(negedge clk);
    op_code = 3'(op);
    opnd_a  = W'(a);
    opnd_b  = W'(b);
    #1;
  endtask

  task automatic sweep(int op, string req);
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b++) begin
        apply(op, a, b);
        check(req, ref_val(op, a, b)); // R1 modulo and carry bit
      end
    end
  endtask

  task automatic t_idle();
    check("R1 idle", 0);
  endtask

  task automatic t_add();       sweep(0, "R3");  endtask
  task automatic t_add_inc();   sweep(1, "R4");  endtask
  task automatic t_sub_ab();    sweep(2, "R5");  endtask
  task automatic t_sub_ba();    sweep(3, "R6");  endtask
  task automatic t_inc();       sweep(4, "R7");  endtask
  task automatic t_mov();       sweep(5, "R8");  endtask
  task automatic t_neg_a();     sweep(6, "R9");  endtask
  task automatic t_neg_b();     sweep(7, "R10"); endtask

  task automatic t_corners();
    apply(4, MAXV, 3);   check("R7 wrap", MOD);
    apply(6, 0, 5);      check("R9 zero", MOD);
    apply(7, 9, 0);      check("R10 zero", MOD);
    apply(2, 6, 6);      check("R5 equal", MOD);
    apply(3, 6, 7);      check("R6 b>a", MOD + 1);
    apply(0, MAXV, MAXV); check("R3 max", 2 * MAXV);
    apply(5, MAXV, MAXV); check("R2 zero B conditioner", MAXV);
    apply(7, MAXV, 1);   check("R2 zero A conditioner", MAXV);
  endtask

  task automatic t_comb_follow();
    @(negedge clk);
    op_code = 3'd0; opnd_a = W'(3); opnd_b = W'(4);
    #0.5;
    check("R11 first", 7);
    opnd_b = W'(9);
    #0.5;
    check("R11 no edge", 12);
    op_code = 3'd2;
    #0.5;
    check("R11 code change", 3 - 9 + MOD);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_idle();
    rst_n = 1'b1;
    t_add();
    t_add_inc();
    t_sub_ab();
    t_sub_ba();
    t_inc();
    t_mov();
    t_neg_a();
    t_neg_b();
    t_corners();
    t_comb_follow();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule